// File: doc/BRIEF.md
# Per-Line Security Access Filter

This block sits beside an event controller and holds the security settings of every event line. For each line it keeps a secure attribute bit, a privileged attribute bit and a compartment word. The compartment word holds a filter-enable flag and a static compartment ID. The block has two jobs. It serves a small register bus whose requester attributes (secure, privileged) arrive as sideband signals. It also answers a combinational query port that asks whether a requester with a given secure flag, privileged flag and compartment ID may use a given line.

Each processor also has a compartment word. The block stores it and reads it back but does not use it for filtering. A trusted requester is one that is both secure and privileged. Only a trusted requester may change the configuration. A sticky global lock, once set, freezes the whole configuration until reset. The event detection logic itself lives elsewhere.

Bus accesses take one cycle. Read data and the error flag are registered, so they appear on the outputs in the cycle after the request.

Top module: `sec_filter`

## Requirements
- R1: After reset every attribute bit, every compartment word and the lock read as zero, `bus_rdata` and `bus_err` are low, an open line is granted to any requester that is not trusted, and it is refused to a trusted requester.
- R2: A trusted query is granted only when both attribute bits of the line are set. The secure bits of bank b sit at address 0x014+0x20*b and the privileged bits at 0x018+0x20*b, with bit n standing for line 32*b+n.
- R3: A query that is not trusted is refused if the line's secure bit is set and the requester is not secure, or if the line's privileged bit is set and the requester is not privileged; otherwise it is granted.
- R4: The compartment word of line i sits at 0x180+4*i, with the enable in bit 0 and the ID in bits 6:4. While the enable is set, a query is granted only if `chk_cid` equals the stored ID, on top of R2/R3.
- R5: The compartment word of processor c sits at 0x300+4*c and has the same layout. It reads back exactly what was written. All bits other than 0 and 6:4 read as zero in every compartment word.
- R6: Only a trusted requester may write a mapped register. A refused write leaves every register unchanged and sets `bus_err` in the next cycle.
- R7: A read of a mapped register by a non-secure requester returns zero and sets `bus_err`. A secure read returns the contents, whether the requester is privileged or not.
- R8: A compartment-word write whose ID exceeds 2^CID_WIDTH-1 (3 by default) is refused as in R6.
- R9: The lock is bit 0 of the register at 0x070. A trusted write with bit 0 set turns it on. Writing zero never clears it; only reset does.
- R10: While the lock is set, every write to an attribute, compartment or lock register is refused with `bus_err` and changes nothing.
- R11: An unmapped or misaligned address reads as zero, ignores writes and never sets `bus_err`.
- R12: `bus_err` is high only in the cycle right after a request and drops in a cycle that follows no request.
- R13: Read data appears in the cycle after the request, and a write returns zero on `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | Requester is secure |
| bus_priv | input | 1 | Requester is privileged |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Refused access, one cycle after the request |
| chk_line | input | 6 | Line being queried |
| chk_sec | input | 1 | Queried requester is secure |
| chk_priv | input | 1 | Queried requester is privileged |
| chk_cid | input | 3 | Queried requester compartment ID |
| chk_grant | output | 1 | Query is granted (combinational) |

## Verification
The assertions assume that a bus request lasts one cycle and that its inputs are stable around the clock edge. They also assume that the query inputs change only between edges, so the grant they sample belongs to the stored configuration. The bench drives every request and query at the falling edge and releases `bus_req` after a single cycle. In the random phase it draws addresses only from the mapped registers plus one unmapped hole, and it never targets the lock register there, so the freeze behaviour is exercised only in the final directed part.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

    localparam int unsigned ADDR_W         = 12;
    localparam int unsigned DATA_W         = 32;
    localparam int unsigned LINES_PER_BANK = 32;
    localparam int unsigned SCID_FW        = 3;
    localparam int unsigned SCID_LSB       = 4;
    localparam int unsigned CFEN_BIT       = 0;

    localparam logic [ADDR_W-1:0] OFS_SEC     = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_PRIV    = 12'h018;
    localparam logic [ADDR_W-1:0] BANK_STRIDE = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h070;
    localparam logic [ADDR_W-1:0] OFS_ECID    = 12'h180;
    localparam logic [ADDR_W-1:0] OFS_CCID    = 12'h300;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_SEC,
        REG_PRIV,
        REG_LOCK,
        REG_ECID,
        REG_CCID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    function automatic logic [DATA_W-1:0] pack_cid(input logic en,
                                                   input logic [SCID_FW-1:0] id);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFEN_BIT] = en;
        w[SCID_LSB +: SCID_FW] = id;
        return w;
    endfunction

endpackage

// File: rtl/sf_decode.sv
module sf_decode
    import sec_filter_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned NUM_CPUS  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_t          sel
);

    localparam logic [ADDR_W-1:0] BANK_END = ADDR_W'(NUM_BANKS * BANK_STRIDE);
    localparam logic [ADDR_W-1:0] ECID_END = ADDR_W'(OFS_ECID + 4 * NUM_LINES);
    localparam logic [ADDR_W-1:0] CCID_END = ADDR_W'(OFS_CCID + 4 * NUM_CPUS);

    logic [ADDR_W-1:0] eoff;
    logic [ADDR_W-1:0] coff;

    assign eoff = addr - OFS_ECID;
    assign coff = addr - OFS_CCID;

    always_comb begin
        sel.kind = REG_NONE;
        sel.idx  = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr < BANK_END) begin
                sel.idx = 8'(addr >> 5);
                if (addr[4:0] == OFS_SEC[4:0]) begin
                    sel.kind = REG_SEC;
                end else if (addr[4:0] == OFS_PRIV[4:0]) begin
                    sel.kind = REG_PRIV;
                end
            end else if (addr == OFS_LOCK) begin
                sel.kind = REG_LOCK;
            end else if (addr >= OFS_ECID && addr < ECID_END) begin
                sel.kind = REG_ECID;
                sel.idx  = 8'(eoff >> 2);
            end else if (addr >= OFS_CCID && addr < CCID_END) begin
                sel.kind = REG_CCID;
                sel.idx  = 8'(coff >> 2);
            end
        end
    end

endmodule

// File: rtl/sf_line_gate.sv
module sf_line_gate
    import sec_filter_pkg::*;
#(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned LINE_W    = 6
) (
    input  logic [NUM_LINES-1:0]              line_sec,
    input  logic [NUM_LINES-1:0]              line_priv,
    input  logic [NUM_LINES-1:0]              line_cfen,
    input  logic [NUM_LINES-1:0][SCID_FW-1:0] line_scid,
    input  logic [LINE_W-1:0]                 q_line,
    input  logic                              q_sec,
    input  logic                              q_priv,
    input  logic [SCID_FW-1:0]                q_cid,
    output logic                              q_grant
);

    localparam int unsigned PAD = 1 << LINE_W;

    logic [NUM_LINES-1:0] ok;
    logic [PAD-1:0]       ok_pad;
    logic                 q_trusted;

    assign q_trusted = q_sec && q_priv;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic cid_ok;
        logic trusted_ok;
        logic open_ok;
        assign cid_ok     = !line_cfen[i] || (line_scid[i] == q_cid);
        assign trusted_ok = line_sec[i] && line_priv[i];
        assign open_ok    = (!line_sec[i] || q_sec) && (!line_priv[i] || q_priv);
        assign ok[i]      = cid_ok && (q_trusted ? trusted_ok : open_ok);
    end

    assign ok_pad  = PAD'(ok);
    assign q_grant = ok_pad[q_line];

endmodule

// File: rtl/sec_filter.sv
module sec_filter
    import sec_filter_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned NUM_CPUS  = 4,
    parameter int unsigned CID_WIDTH = 2,
    localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK,
    localparam int unsigned LINE_W    = $clog2(NUM_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_sec,
    input  logic               bus_priv,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    input  logic [LINE_W-1:0]  chk_line,
    input  logic               chk_sec,
    input  logic               chk_priv,
    input  logic [SCID_FW-1:0] chk_cid,
    output logic               chk_grant
);

    localparam logic [SCID_FW-1:0] MAX_CID = SCID_FW'((1 << CID_WIDTH) - 1);

    typedef struct packed {
        logic [NUM_LINES-1:0]              sec;
        logic [NUM_LINES-1:0]              priv;
        logic [NUM_LINES-1:0]              cfen;
        logic [NUM_LINES-1:0][SCID_FW-1:0] scid;
        logic [NUM_CPUS-1:0]               ccfen;
        logic [NUM_CPUS-1:0][SCID_FW-1:0]  cscid;
        logic                              lock;
        logic [DATA_W-1:0]                 rdata;
        logic                              err;
    } state_t;

    state_t st_d, st_q;

    reg_sel_t           sel;
    logic [DATA_W-1:0]  rd_val;
    logic [SCID_FW-1:0] wcid;
    logic               trusted;
    logic               is_cid_word;
    logic               cid_legal;
    logic               wr_ok;

    sf_decode #(
        .NUM_BANKS (NUM_BANKS),
        .NUM_LINES (NUM_LINES),
        .NUM_CPUS  (NUM_CPUS)
    ) i_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wcid        = bus_wdata[SCID_LSB +: SCID_FW];
    assign trusted     = bus_sec && bus_priv;
    assign is_cid_word = (sel.kind == REG_ECID) || (sel.kind == REG_CCID);
    assign cid_legal   = (wcid <= MAX_CID);
    assign wr_ok       = trusted && !st_q.lock && (!is_cid_word || cid_legal);

    // Read multiplexer over the current register contents
    always_comb begin
        rd_val = '0;
        case (sel.kind)
            REG_SEC: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.idx == 8'(b)) begin
                        rd_val = st_q.sec[b*LINES_PER_BANK +: LINES_PER_BANK];
                    end
                end
            end
            REG_PRIV: begin
                for (int b = 0; b < NUM_BANKS; b++) begin
                    if (sel.idx == 8'(b)) begin
                        rd_val = st_q.priv[b*LINES_PER_BANK +: LINES_PER_BANK];
                    end
                end
            end
            REG_LOCK: rd_val = {{(DATA_W-1){1'b0}}, st_q.lock};
            REG_ECID: begin
                for (int i = 0; i < NUM_LINES; i++) begin
                    if (sel.idx == 8'(i)) begin
                        rd_val = pack_cid(st_q.cfen[i], st_q.scid[i]);
                    end
                end
            end
            REG_CCID: begin
                for (int c = 0; c < NUM_CPUS; c++) begin
                    if (sel.idx == 8'(c)) begin
                        rd_val = pack_cid(st_q.ccfen[c], st_q.cscid[c]);
                    end
                end
            end
            default: rd_val = '0;
        endcase
    end

    // Next-state computation
    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = 1'b0;
        if (bus_req && (sel.kind != REG_NONE)) begin
            if (bus_we) begin
                if (wr_ok) begin
                    case (sel.kind)
                        REG_SEC: begin
                            for (int b = 0; b < NUM_BANKS; b++) begin
                                if (sel.idx == 8'(b)) begin
                                    st_d.sec[b*LINES_PER_BANK +: LINES_PER_BANK] = bus_wdata;
                                end
                            end
                        end
                        REG_PRIV: begin
                            for (int b = 0; b < NUM_BANKS; b++) begin
                                if (sel.idx == 8'(b)) begin
                                    st_d.priv[b*LINES_PER_BANK +: LINES_PER_BANK] = bus_wdata;
                                end
                            end
                        end
                        REG_LOCK: st_d.lock = st_q.lock | bus_wdata[0];
                        REG_ECID: begin
                            for (int i = 0; i < NUM_LINES; i++) begin
                                if (sel.idx == 8'(i)) begin
                                    st_d.cfen[i] = bus_wdata[CFEN_BIT];
                                    st_d.scid[i] = wcid;
                                end
                            end
                        end
                        REG_CCID: begin
                            for (int c = 0; c < NUM_CPUS; c++) begin
                                if (sel.idx == 8'(c)) begin
                                    st_d.ccfen[c] = bus_wdata[CFEN_BIT];
                                    st_d.cscid[c] = wcid;
                                end
                            end
                        end
                        default: st_d.err = 1'b0;
                    endcase
                end else begin
                    st_d.err = 1'b1;
                end
            end else if (bus_sec) begin
                st_d.rdata = rd_val;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;

    sf_line_gate #(
        .NUM_LINES (NUM_LINES),
        .LINE_W    (LINE_W)
    ) i_gate (
        .line_sec  (st_q.sec),
        .line_priv (st_q.priv),
        .line_cfen (st_q.cfen),
        .line_scid (st_q.scid),
        .q_line    (chk_line),
        .q_sec     (chk_sec),
        .q_priv    (chk_priv),
        .q_cid     (chk_cid),
        .q_grant   (chk_grant)
    );

endmodule

// File: rtl/sec_filter_chk.sv
module sec_filter_chk #(
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned LINE_W    = 6,
    parameter int unsigned CFG_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic                 bus_sec,
    input logic                 bus_priv,
    input logic [31:0]          bus_rdata,
    input logic                 bus_err,
    input logic [LINE_W-1:0]    chk_line,
    input logic                 chk_sec,
    input logic                 chk_priv,
    input logic                 chk_grant,
    input logic                 lock,
    input logic [CFG_W-1:0]     cfg_vec,
    input logic [NUM_LINES-1:0] line_sec,
    input logic [NUM_LINES-1:0] line_priv
);

    assert_trusted_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_grant && chk_sec && chk_priv) |-> (line_sec[chk_line] && line_priv[chk_line]));

    assert_untrusted_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !(bus_sec && bus_priv)) |=> ($stable(cfg_vec) && $stable(lock)));

    assert_nonsec_read_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !bus_sec) |=> (bus_rdata == 32'h0));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    assert_frozen_when_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(cfg_vec));

    assert_err_follows_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_req));

    assert_write_returns_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> (bus_rdata == 32'h0));

endmodule

bind sec_filter sec_filter_chk #(
    .NUM_LINES (NUM_LINES),
    .LINE_W    (LINE_W),
    .CFG_W     (3 * NUM_LINES + NUM_LINES * sec_filter_pkg::SCID_FW
                + NUM_CPUS * (1 + sec_filter_pkg::SCID_FW))
) i_sec_filter_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_sec   (bus_sec),
    .bus_priv  (bus_priv),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .chk_line  (chk_line),
    .chk_sec   (chk_sec),
    .chk_priv  (chk_priv),
    .chk_grant (chk_grant),
    .lock      (st_q.lock),
    .cfg_vec   ({st_q.sec, st_q.priv, st_q.cfen, st_q.scid, st_q.ccfen, st_q.cscid}),
    .line_sec  (st_q.sec),
    .line_priv (st_q.priv)
);

// File: tb/test_sec_filter.sv
module test_sec_filter;

    localparam int NB   = 2;
    localparam int NL   = 64;
    localparam int NC   = 4;
    localparam int MAXC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_sec = 1'b0;
    logic        bus_priv = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [5:0]  chk_line = '0;
    logic        chk_sec = 1'b0;
    logic        chk_priv = 1'b0;
    logic [2:0]  chk_cid = '0;
    logic        chk_grant;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    bit m_sec [NL];
    bit m_priv [NL];
    bit m_cfen [NL];
    int m_scid [NL];
    bit m_ccfen [NC];
    int m_cscid [NC];
    bit m_lock;

    always #5 clk = ~clk;

    sec_filter i_sec_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_sec   (bus_sec),
        .bus_priv  (bus_priv),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .chk_line  (chk_line),
        .chk_sec   (chk_sec),
        .chk_priv  (chk_priv),
        .chk_cid   (chk_cid),
        .chk_grant (chk_grant)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench-side address map: 0 none, 1 secure bits, 2 privileged bits,
    // 3 lock, 4 line compartment word, 5 processor compartment word
    function automatic int decode(input int addr, output int idx);
        idx = 0;
        if (addr % 4 != 0) return 0;
        if (addr < NB * 'h20) begin
            idx = addr / 'h20;
            if (addr % 'h20 == 'h14) return 1;
            if (addr % 'h20 == 'h18) return 2;
            return 0;
        end
        if (addr == 'h70) return 3;
        if (addr >= 'h180 && addr < 'h180 + 4 * NL) begin
            idx = (addr - 'h180) / 4;
            return 4;
        end
        if (addr >= 'h300 && addr < 'h300 + 4 * NC) begin
            idx = (addr - 'h300) / 4;
            return 5;
        end
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input int k, input int idx);
        logic [31:0] v;
        v = '0;
        case (k)
            1: for (int n = 0; n < 32; n++) v[n] = m_sec[idx * 32 + n];
            2: for (int n = 0; n < 32; n++) v[n] = m_priv[idx * 32 + n];
            3: v[0] = m_lock;
            4: begin v[0] = m_cfen[idx]; v[6:4] = 3'(m_scid[idx]); end
            5: begin v[0] = m_ccfen[idx]; v[6:4] = 3'(m_cscid[idx]); end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic bit model_grant(input int line, input bit s, input bit p, input int cid);
        bit cid_ok;
        cid_ok = !m_cfen[line] || (m_scid[line] == cid);
        if (s && p) return cid_ok && m_sec[line] && m_priv[line];
        return cid_ok && (!m_sec[line] || s) && (!m_priv[line] || p);
    endfunction

    task automatic bus_op(input bit we, input int addr, input logic [31:0] wd,
                          input bit s, input bit p, input string tag);
        int k;
        int idx;
        logic [31:0] er;
        bit ee;
        k  = decode(addr, idx);
        er = '0;
        ee = 1'b0;
        if (k != 0) begin
            if (we) begin
                if (s && p && !m_lock && ((k != 4 && k != 5) || int'(wd[6:4]) <= MAXC)) begin
                    case (k)
                        1: for (int n = 0; n < 32; n++) m_sec[idx * 32 + n] = wd[n];
                        2: for (int n = 0; n < 32; n++) m_priv[idx * 32 + n] = wd[n];
                        3: m_lock = m_lock | wd[0];
                        4: begin m_cfen[idx] = wd[0]; m_scid[idx] = int'(wd[6:4]); end
                        5: begin m_ccfen[idx] = wd[0]; m_cscid[idx] = int'(wd[6:4]); end
                        default: ;
                    endcase
                end else begin
                    ee = 1'b1;
                end
            end else if (s) begin
                er = model_read(k, idx);
            end else begin
                ee = 1'b1;
            end
        end
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = 12'(addr);
        bus_wdata = wd;
        bus_sec   = s;
        bus_priv  = p;
        @(negedge clk);
        bus_req = 1'b0;
        check(bus_rdata === er, {tag, " rdata"}, bus_rdata, er);
        check(bus_err === ee, {tag, " err"}, 32'(bus_err), 32'(ee));
    endtask

    task automatic q_check(input int line, input bit s, input bit p, input int cid,
                           input string tag);
        bit eg;
        @(negedge clk);
        chk_line = 6'(line);
        chk_sec  = s;
        chk_priv = p;
        chk_cid  = 3'(cid);
        #1;
        eg = model_grant(line, s, p, cid);
        check(chk_grant === eg, {tag, " grant"}, 32'(chk_grant), 32'(eg));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7321));
        m_lock = 1'b0;
        for (int i = 0; i < NL; i++) begin
            m_sec[i] = 0; m_priv[i] = 0; m_cfen[i] = 0; m_scid[i] = 0;
        end
        for (int c = 0; c < NC; c++) begin
            m_ccfen[c] = 0; m_cscid[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(bus_rdata === 32'h0, "R1 rdata", bus_rdata, 32'h0);
        check(bus_err === 1'b0, "R1 err", 32'(bus_err), 32'h0);
        q_check(5, 0, 0, 0, "R1");
        q_check(5, 1, 1, 0, "R1");
        bus_op(0, 'h014, 0, 1, 1, "R1");
        bus_op(0, 'h1a0, 0, 1, 1, "R1");

        // R2 / R3: attribute bits
        bus_op(1, 'h014, 32'h0000_00f0, 1, 1, "R2");
        bus_op(1, 'h018, 32'h0000_0030, 1, 1, "R2");
        bus_op(1, 'h034, 32'h8000_0001, 1, 1, "R2");
        bus_op(1, 'h038, 32'h8000_0000, 1, 1, "R2");
        q_check(4, 1, 1, 0, "R2");
        q_check(6, 1, 1, 0, "R2");
        q_check(63, 1, 1, 0, "R2");
        q_check(32, 1, 1, 0, "R2");
        q_check(6, 0, 0, 0, "R3");
        q_check(6, 1, 0, 0, "R3");
        q_check(4, 1, 0, 0, "R3");
        q_check(4, 0, 1, 0, "R3");
        q_check(10, 0, 1, 0, "R3");

        // R6: untrusted writes refused
        bus_op(1, 'h038, 32'hffff_ffff, 1, 0, "R6");
        bus_op(0, 'h038, 0, 1, 0, "R6");
        bus_op(1, 'h184, 32'h0000_0011, 0, 1, "R6");

        // R12: error drops after an idle cycle
        @(negedge clk);
        check(bus_err === 1'b0, "R12 idle err", 32'(bus_err), 32'h0);

        // R4: line compartment filter
        bus_op(1, 'h190, 32'hffff_ff11, 1, 1, "R4");
        bus_op(0, 'h190, 0, 1, 1, "R4");
        q_check(4, 1, 1, 1, "R4");
        q_check(4, 1, 1, 2, "R4");
        bus_op(1, 'h188, 32'h0000_0021, 1, 1, "R4");
        q_check(2, 0, 0, 2, "R4");
        q_check(2, 0, 0, 1, "R4");

        // R8: compartment ID range
        bus_op(1, 'h190, 32'h0000_0051, 1, 1, "R8");
        bus_op(0, 'h190, 0, 1, 1, "R8");
        bus_op(1, 'h308, 32'h0000_0071, 1, 1, "R8");

        // R5: processor compartment words
        bus_op(1, 'h308, 32'hffff_ff3f, 1, 1, "R5");
        bus_op(0, 'h308, 0, 1, 1, "R5");
        bus_op(0, 'h30c, 0, 1, 1, "R5");

        // R7: read permissions
        bus_op(0, 'h014, 0, 0, 1, "R7");
        bus_op(0, 'h014, 0, 1, 0, "R7");

        // R11: unmapped and misaligned
        bus_op(1, 'h100, 32'hffff_ffff, 1, 1, "R11");
        bus_op(0, 'h100, 0, 1, 1, "R11");
        bus_op(1, 'h016, 32'hffff_ffff, 1, 1, "R11");
        bus_op(0, 'h3fc, 0, 0, 0, "R11");
        bus_op(0, 'h014, 0, 1, 1, "R11");

        // Random phase (lock register excluded)
        for (int it = 0; it < 400; it++) begin
            int r;
            int a;
            int at;
            logic [31:0] wd;
            r = int'($urandom % 8);
            case (r)
                0: a = int'($urandom % NB) * 'h20 + 'h14;
                1: a = int'($urandom % NB) * 'h20 + 'h18;
                2, 3, 4: a = 'h180 + 4 * int'($urandom % NL);
                5: a = 'h300 + 4 * int'($urandom % NC);
                default: a = 'h0a0;
            endcase
            wd = $urandom;
            at = int'($urandom % 4);
            bus_op(($urandom % 2) == 1, a, wd, at != 0, at != 1, "R13");
            q_check(int'($urandom % NL), ($urandom % 2) == 1, ($urandom % 2) == 1,
                    int'($urandom % 8), "R4");
        end

        // R9 / R10: global lock
        bus_op(1, 'h070, 32'hffff_fffe, 1, 1, "R9");
        bus_op(0, 'h070, 0, 1, 1, "R9");
        bus_op(1, 'h070, 32'h0000_0001, 1, 0, "R9");
        bus_op(1, 'h070, 32'h0000_0001, 1, 1, "R9");
        bus_op(0, 'h070, 0, 1, 1, "R9");
        bus_op(1, 'h070, 32'h0000_0000, 1, 1, "R9");
        bus_op(0, 'h070, 0, 1, 1, "R9");
        bus_op(1, 'h014, 32'h1234_5678, 1, 1, "R10");
        bus_op(0, 'h014, 0, 1, 1, "R10");
        bus_op(1, 'h1fc, 32'h0000_0001, 1, 1, "R10");
        bus_op(0, 'h1fc, 0, 1, 1, "R10");
        bus_op(1, 'h300, 32'h0000_0011, 1, 1, "R10");
        q_check(4, 1, 1, 1, "R10");
        @(negedge clk);
        check(bus_err === 1'b0, "R12 idle err", 32'(bus_err), 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule